// File: doc/BRIEF.md
# Serial Frame Aligner with Byte/Nibble Deserializer

This block sits behind a clock-and-data recovery stage on a SONET/SDH receive path. Every cycle of the recovered bit clock it takes in one serial bit. It hunts for the 48-bit framing pattern, fixes the byte boundary where that pattern ends, and presents aligned bytes, or nibbles, on a parallel interface. The parallel clock is derived from a free-running divider inside the same serial clock domain. A frame pulse marks the parallel word that completes the framing pattern.

The hunt is armed by a rising edge on an asynchronous out-of-frame input. The hunt stays armed while that input is high. Once at least one pattern has been found and the input has gone low, the hunt turns off. From then on the byte boundary is frozen, and only patterns that land on that boundary produce a frame pulse. This guards an established alignment against mimic patterns in the payload. Two signal-detect inputs with complementary polarity conventions decide whether the line carries valid data. When they report loss of signal, the received bits are replaced by zeros.

The parallel clock never stretches or shrinks when the block reframes. A realignment only changes which bits make up the next word. Any partially assembled word is discarded.

Top module: `sonet_byte_framer`

## Requirements
- R1: The framing pattern is three 8'hF0 bytes followed by three 8'h28 bytes, received most significant bit first (48 bits in total). A match is declared on the clock edge that samples the last bit of the pattern.
- R2: After reset the hunt is off, and `par_data`, `frame_pulse` and `word_stb` are 0. The hunt is switched on only by a low-to-high transition of `oof_async`, seen after a two-stage synchronizer.
- R3: The hunt stays on while the synchronized `oof_async` is high. It switches off once a pattern has been found since the last arming edge and the synchronized `oof_async` is low.
- R4: A match while the hunt is on realigns the boundary, so that the last pattern bit becomes the last bit of a byte. The word that ends there is presented at the next parallel tick with `frame_pulse` = 1, and `frame_pulse` stays 1 for exactly that one parallel period. In byte mode this word is 8'h28.
- R5: While the hunt is off, the boundary is held. A pattern that ends on any bit other than the held byte's last bit produces no frame pulse and does not move the boundary.
- R6: `word_stb` pulses for one serial clock every 8 serial clocks in byte mode and every 4 in nibble mode, whatever the realignments. `par_clk` rises on the cycle that `word_stb` is high.
- R7: With `nibble_mode` = 1, words are 4 bits wide and appear on `par_data[7:4]`, the high nibble of each byte first, with `par_data[3:0]` = 0. A realignment ends a nibble as well as a byte.
- R8: Serial data is used only when `sd_pecl` XOR `sd_ttl` is 1. Otherwise every received bit is taken as 0.
- R9: A word completed on a serial edge is presented at the next parallel tick. If two words complete between ticks, only the later one is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data bit, one per clock |
| sd_pecl | input | 1 | Signal detect, polarity set by `sd_ttl` |
| sd_ttl | input | 1 | Signal detect, polarity set by `sd_pecl` |
| oof_async | input | 1 | Out-of-frame request, asynchronous |
| nibble_mode | input | 1 | 1 selects 4-bit words, 0 selects 8-bit words |
| par_clk | output | 1 | Parallel clock, rises at word updates |
| word_stb | output | 1 | One-cycle strobe marking a new parallel word |
| par_data | output | 8 | Parallel word (nibbles on bits 7:4) |
| frame_pulse | output | 1 | High for the parallel period of the pattern's last word |

## Verification
The aligner is driven with random payload bytes into which framing patterns are inserted at random bit offsets. This shows whether realignment follows the pattern wherever it falls, or only when it is already aligned. Arming pulses of random length and random signal-detect pairs are mixed in. They separate the held-boundary behaviour from the hunting behaviour, and they check the forced-zero line. In a directed sequence, a pattern is shifted by three bits after lock and must produce no pulse, and then a re-aligned pattern must produce one. In nibble mode the pulse word must be 4'h8 in the upper nibble.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned SFR_BYTE_W = 8;
  localparam int unsigned SFR_HALF_W = SFR_BYTE_W / 2;
  localparam int unsigned SFR_CNT_W  = $clog2(SFR_BYTE_W);

  // Line is valid when exactly one detect input is high.
  function automatic logic line_valid(input logic det_a, input logic det_b);
    return det_a ^ det_b;
  endfunction

  // Last bit of a word, for a given bit position and width mode.
  function automatic logic word_boundary(input logic [SFR_CNT_W-1:0] pos,
                                         input logic nib);
    logic [SFR_CNT_W-1:0] lim;
    lim = SFR_CNT_W'(SFR_BYTE_W - 1);
    if (nib) return pos[SFR_CNT_W-2:0] == lim[SFR_CNT_W-2:0];
    return pos == lim;
  endfunction

  // Parallel tick derived from the free-running phase counter.
  function automatic logic par_tick(input logic [SFR_CNT_W-1:0] ph,
                                    input logic nib);
    return word_boundary(ph, nib);
  endfunction
endpackage

// File: rtl/sfr_oof_sync.sv
module sfr_oof_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oof_async,
  output logic oof_level,
  output logic oof_rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], oof_async};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign oof_level = sync_q[STAGES-1];
  assign oof_rise  = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sfr_hunt.sv
module sfr_hunt
  import sfr_pkg::*;
#(
  parameter logic [SFR_BYTE_W-1:0] A1_BYTE = 8'hF0,
  parameter logic [SFR_BYTE_W-1:0] A2_BYTE = 8'h28,
  parameter int unsigned A1_COUNT = 3,
  parameter int unsigned A2_COUNT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_in,
  input  logic                  oof_level,
  input  logic                  oof_rise,
  input  logic                  nibble,
  output logic                  word_done,
  output logic [SFR_BYTE_W-1:0] word_val,
  output logic                  frame_hit,
  output logic                  pattern_seen,
  output logic                  hunt_on,
  output logic                  byte_last
);
  localparam int unsigned N_BYTES = A1_COUNT + A2_COUNT;
  localparam int unsigned PAT_W   = SFR_BYTE_W * N_BYTES;

  logic [PAT_W-1:0]     pattern;
  logic [PAT_W-1:0]     shift_q;
  logic [PAT_W-1:0]     shift_nx;
  logic [SFR_CNT_W-1:0] pos_q;
  logic                 found_q;
  logic                 hunt_q;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_pat
    if (g < A1_COUNT) begin : g_a1
      assign pattern[PAT_W-1-g*SFR_BYTE_W -: SFR_BYTE_W] = A1_BYTE;
    end else begin : g_a2
      assign pattern[PAT_W-1-g*SFR_BYTE_W -: SFR_BYTE_W] = A2_BYTE;
    end
  end

  assign shift_nx     = {shift_q[PAT_W-2:0], bit_in};
  assign pattern_seen = (shift_nx == pattern);
  assign byte_last    = (pos_q == SFR_CNT_W'(SFR_BYTE_W - 1));
  assign frame_hit    = pattern_seen & (hunt_q | byte_last);
  assign word_done    = frame_hit | word_boundary(pos_q, nibble);
  assign word_val     = nibble ? {shift_nx[SFR_HALF_W-1:0], {SFR_HALF_W{1'b0}}}
                               : shift_nx[SFR_BYTE_W-1:0];
  assign hunt_on      = hunt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      pos_q   <= '0;
      found_q <= 1'b0;
      hunt_q  <= 1'b0;
    end else begin
      shift_q <= shift_nx;
      pos_q   <= frame_hit ? '0 : pos_q + 1'b1;
      if (oof_rise) begin
        hunt_q  <= 1'b1;
        found_q <= 1'b0;
      end else if (hunt_q) begin
        if (pattern_seen) found_q <= 1'b1;
        if ((found_q | pattern_seen) & ~oof_level) hunt_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sfr_deser.sv
module sfr_deser
  import sfr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nibble,
  input  logic                  word_done,
  input  logic [SFR_BYTE_W-1:0] word_val,
  input  logic                  word_frame,
  output logic                  tick,
  output logic                  par_clk,
  output logic                  word_stb,
  output logic [SFR_BYTE_W-1:0] par_data,
  output logic                  frame_pulse
);
  logic [SFR_CNT_W-1:0]  phase_q;
  logic [SFR_BYTE_W-1:0] hold_q;
  logic                  hold_fp_q;

  assign tick    = par_tick(phase_q, nibble);
  assign par_clk = nibble ? ~phase_q[SFR_CNT_W-2] : ~phase_q[SFR_CNT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= '0;
      hold_q      <= '0;
      hold_fp_q   <= 1'b0;
      word_stb    <= 1'b0;
      par_data    <= '0;
      frame_pulse <= 1'b0;
    end else begin
      phase_q  <= phase_q + 1'b1;
      word_stb <= tick;
      if (tick) begin
        par_data    <= hold_q;
        frame_pulse <= hold_fp_q;
      end
      if (word_done) begin
        hold_q    <= word_val;
        hold_fp_q <= word_frame;
      end else if (tick) begin
        hold_fp_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sonet_byte_framer.sv
module sonet_byte_framer
  import sfr_pkg::*;
#(
  parameter logic [7:0] A1_BYTE  = 8'hF0,
  parameter logic [7:0] A2_BYTE  = 8'h28,
  parameter int unsigned A1_COUNT = 3,
  parameter int unsigned A2_COUNT = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  input  logic       sd_pecl,
  input  logic       sd_ttl,
  input  logic       oof_async,
  input  logic       nibble_mode,
  output logic       par_clk,
  output logic       word_stb,
  output logic [7:0] par_data,
  output logic       frame_pulse
);
  logic                  bit_in;
  logic                  oof_level;
  logic                  oof_rise;
  logic                  word_done;
  logic [SFR_BYTE_W-1:0] word_val;
  logic                  frame_hit;
  logic                  pattern_seen;
  logic                  hunt_on;
  logic                  byte_last;
  logic                  tick;

  assign bit_in = ser_in & line_valid(sd_pecl, sd_ttl);

  sfr_oof_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .oof_async(oof_async),
    .oof_level(oof_level), .oof_rise(oof_rise)
  );

  sfr_hunt #(
    .A1_BYTE(A1_BYTE), .A2_BYTE(A2_BYTE),
    .A1_COUNT(A1_COUNT), .A2_COUNT(A2_COUNT)
  ) u_hunt (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
    .oof_level(oof_level), .oof_rise(oof_rise), .nibble(nibble_mode),
    .word_done(word_done), .word_val(word_val), .frame_hit(frame_hit),
    .pattern_seen(pattern_seen), .hunt_on(hunt_on), .byte_last(byte_last)
  );

  sfr_deser u_deser (
    .clk(clk), .rst_n(rst_n), .nibble(nibble_mode),
    .word_done(word_done), .word_val(word_val), .word_frame(frame_hit),
    .tick(tick), .par_clk(par_clk), .word_stb(word_stb),
    .par_data(par_data), .frame_pulse(frame_pulse)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic clk,
  input logic rst_n,
  input logic nibble_mode,
  input logic word_stb,
  input logic par_clk,
  input logic frame_pulse,
  input logic oof_level,
  input logic oof_rise,
  input logic hunt_on,
  input logic pattern_seen,
  input logic frame_hit,
  input logic byte_last
);
  logic [4:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= word_stb ? 5'd1 : ((gap_q == 5'd31) ? gap_q : gap_q + 5'd1);
      seen_q <= seen_q | word_stb;
    end
  end

  // R6: strobe spacing never changes
  a_r6_strobe_period: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && seen_q) |-> (gap_q == (nibble_mode ? 5'd4 : 5'd8)));

  // R6: parallel clock rises with the strobe
  a_r6_clk_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> par_clk);

  // R2: hunt only starts after a synchronized rising edge
  a_r2_arm_by_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hunt_on) |-> $past(oof_rise));

  // R3: hunt held on while the request is high
  a_r3_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt_on && oof_level) |=> hunt_on);

  // R5: with the hunt off only aligned patterns count
  a_r5_held_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (!hunt_on && pattern_seen && !byte_last) |-> !frame_hit);

  // R4: a frame pulse starts with a new parallel word
  a_r4_pulse_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_pulse) |-> word_stb);
endmodule

bind sonet_byte_framer sfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode),
  .word_stb(word_stb), .par_clk(par_clk), .frame_pulse(frame_pulse),
  .oof_level(oof_level), .oof_rise(oof_rise), .hunt_on(hunt_on),
  .pattern_seen(pattern_seen), .frame_hit(frame_hit), .byte_last(byte_last)
);

// File: tb/sonet_byte_framer_tb.sv
module sonet_byte_framer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, sd_pecl = 1'b1, sd_ttl = 1'b0, oof_async = 1'b0, nibble_mode = 1'b0;
  logic par_clk, word_stb, frame_pulse;
  logic [7:0] par_data;

  int n_checks = 0, n_fail = 0, fp_count = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sonet_byte_framer u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sd_pecl(sd_pecl), .sd_ttl(sd_ttl),
    .oof_async(oof_async), .nibble_mode(nibble_mode), .par_clk(par_clk),
    .word_stb(word_stb), .par_data(par_data), .frame_pulse(frame_pulse)
  );

  // Reference model built from the requirements
  logic [7:0]  hist [6];
  logic [2:0]  m_pos, m_ph;
  logic        m_o1, m_o2, m_o3, m_hunt, m_found;
  logic [7:0]  m_hold, m_data;
  logic        m_hold_fp, m_fp, m_stb;

  function automatic bit is_frame();
    for (int i = 0; i < 6; i++)
      if (hist[i] !== ((i < 3) ? 8'hF0 : 8'h28)) return 0;
    return 1;
  endfunction

  function automatic bit ends_word(input logic [2:0] p, input logic nib);
    return nib ? (p % 4 == 3) : (p == 7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) hist[i] = 8'h00;
      m_pos = 0; m_ph = 0; m_o1 = 0; m_o2 = 0; m_o3 = 0; m_hunt = 0; m_found = 0;
      m_hold = 0; m_data = 0; m_hold_fp = 0; m_fp = 0; m_stb = 0;
    end else begin
      logic b, hit, seen, rise, done, tk;
      logic [7:0] w;
      b = ser_in && (sd_pecl != sd_ttl);                       // R8
      for (int i = 0; i < 5; i++) hist[i] = {hist[i][6:0], hist[i+1][7]};
      hist[5] = {hist[5][6:0], b};
      seen = is_frame();                                         // R1
      rise = m_o2 && !m_o3;
      hit  = seen && (m_hunt || m_pos == 7);                     // R4 R5
      done = hit || ends_word(m_pos, nibble_mode);
      w    = nibble_mode ? {hist[5][3:0], 4'h0} : hist[5];       // R7
      tk   = ends_word(m_ph, nibble_mode);                       // R6
      m_stb = tk;
      if (tk) begin m_data = m_hold; m_fp = m_hold_fp; end       // R9
      if (done) begin m_hold = w; m_hold_fp = hit; end
      else if (tk) m_hold_fp = 0;
      if (rise) begin m_hunt = 1; m_found = 0; end               // R2
      else if (m_hunt) begin
        if (seen) m_found = 1;
        if ((m_found || seen) && !m_o2) m_hunt = 0;              // R3
      end
      m_pos = hit ? 3'd0 : m_pos + 3'd1;
      m_ph  = m_ph + 3'd1;
      m_o3 = m_o2; m_o2 = m_o1; m_o1 = oof_async;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    check(word_stb === m_stb, "R6 strobe", word_stb, m_stb);
    check(par_clk === (nibble_mode ? ~m_ph[1] : ~m_ph[2]), "R6 par_clk", par_clk,
          nibble_mode ? ~m_ph[1] : ~m_ph[2]);
    if (word_stb) begin
      check(par_data === m_data, "R9 word", par_data, m_data);
      check(frame_pulse === m_fp, "R4 pulse", frame_pulse, m_fp);
      if (frame_pulse === 1'b1) begin
        fp_count++;
        check(par_data === (nibble_mode ? 8'h80 : 8'h28), "R1 R7 pulse word", par_data,
              nibble_mode ? 8'h80 : 8'h28);
      end
    end
  end

  task automatic put_bit(input logic b);
    @(negedge clk); ser_in = b;
  endtask
  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask
  task automatic put_frame();
    for (int i = 0; i < 6; i++) put_byte(i < 3 ? 8'hF0 : 8'h28);
  endtask
  task automatic do_reset(input logic nib);
    @(negedge clk); rst_n = 0; nibble_mode = nib; oof_async = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask
  task automatic lock_on();
    @(negedge clk); oof_async = 1;
    repeat (4) put_byte(8'h55);
    put_frame();
    oof_async = 0;
    repeat (4) put_byte(8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h5EED_1234));
    do_reset(0);
    @(negedge clk);
    check(par_data === 8'h00 && frame_pulse === 1'b0 && word_stb === 1'b0,
          "R2 reset state", {frame_pulse, par_data}, 0);

    // R2: pattern without arming edge gives no pulse
    base = fp_count;
    repeat (3) put_byte(8'h55);
    put_bit(1'b0); put_frame(); repeat (4) put_byte(8'h55);
    check(fp_count == base, "R2 no arm no pulse", fp_count - base, 0);

    // R4: armed hunt finds a misaligned pattern
    base = fp_count;
    lock_on();
    check(fp_count == base + 1, "R4 lock pulse", fp_count - base, 1);

    // R3 R5: hunt now off, a 3-bit shifted pattern is ignored
    base = fp_count;
    repeat (3) put_bit(1'b0);
    put_frame(); repeat (4) put_byte(8'h55);
    check(fp_count == base, "R5 shifted ignored", fp_count - base, 0);
    // realign by 5 bits: pattern on held boundary
    repeat (5) put_bit(1'b0);
    put_frame(); repeat (4) put_byte(8'h55);
    check(fp_count == base + 1, "R5 aligned pulse", fp_count - base, 1);

    // R8: loss of signal forces zeros
    sd_pecl = 1; sd_ttl = 1;
    repeat (3) put_byte(8'hFF);
    repeat (4) begin
      @(negedge clk); while (!word_stb) @(negedge clk);
      check(par_data === 8'h00, "R8 los zero", par_data, 0);
      put_byte(8'hFF);
    end
    sd_pecl = 0; sd_ttl = 1;

    // Random mix, byte mode then nibble mode
    for (int mode = 0; mode < 2; mode++) begin
      do_reset(mode[0]);
      base = fp_count;
      lock_on();
      check(fp_count > base, mode ? "R7 nibble lock" : "R4 byte lock", fp_count - base, 1);
      for (int f = 0; f < 120; f++) begin
        int nfill = 2 + $urandom_range(0, 12);
        for (int k = 0; k < nfill; k++) put_byte(8'($urandom));
        repeat ($urandom_range(0, 7)) put_bit(1'($urandom));
        if ($urandom_range(0, 3) == 0) oof_async = 1;
        if ($urandom_range(0, 9) == 0) begin
          sd_pecl = 1'($urandom); sd_ttl = 1'($urandom);
        end
        put_frame();
        if ($urandom_range(0, 1) == 0) oof_async = 0;
        sd_pecl = 1; sd_ttl = 0;
      end
      oof_async = 0;
      repeat (4) put_byte(8'h55);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule